// File: doc/BRIEF.md
# Packed-Integer SIMD Fault Checker

This block decides, before a packed-integer SIMD operation executes, whether the operation must trap and with which fault. Decode and address generation supply the processor mode, the operand width (64-bit or 128-bit), whether a memory operand is used, its effective address and the segment and canonical checks that were already made. The control bits, privilege level, feature bit, pending x87 state and the page-fault result of the translation unit are also inputs. The set of faults that can arise depends on the operand width and on the mode.

Each request on `req_valid` produces a registered result one cycle later. The result is a one-hot fault vector and a matching 3-bit code. When several conditions hold at once, only the fault with the highest fixed priority is reported. Conditions that depend on the memory operand are evaluated only while `has_mem` is high.

Top module: `simd_fault_chk`

## Requirements
- R1: Fault UD (code 1, vector bit 0) is raised for either width when `lock_prefix` or `cr_emulate` is 1.
- R2: For 128-bit operations only (`wide`=1), UD is also raised when `cr_os_simd` is 0 or `simd_feat` is 0. For 64-bit operations these two inputs have no effect.
- R3: Fault NM (code 2, vector bit 1) is raised when `cr_task_sw` is 1.
- R4: Fault MF (code 3, vector bit 2) is raised when `x87_pend` is 1, for 64-bit operations only.
- R5: A 128-bit memory operand whose address bits [3:0] are not zero raises GP (code 5, vector bit 4) in every mode.
- R6: In real mode (`mode`=0) and virtual-8086 mode (`mode`=1), a memory operand whose last byte (address + 7, or + 15 when wide) lies above 0xFFFF raises GP.
- R7: In 64-bit mode (`mode`=4), a memory operand with `addr_canonical`=0 raises SS (code 4, vector bit 3) when `stack_ref`=1 and GP otherwise. In other modes the canonical input has no effect.
- R8: In protected (`mode`=2) and compatibility (`mode`=3) modes, `stk_limit_viol` raises SS and `seg_limit_viol` raises GP for a memory operand. In other modes these inputs have no effect.
- R9: `page_fault_in` raises PF (code 6, vector bit 5) for a memory operand in every mode except real mode.
- R10: AC (code 7, vector bit 6) is raised for a 64-bit memory operand when `cr_align_en`=1 and address bits [2:0] are not zero. It is raised in virtual-8086 mode at any privilege level, in modes 2 to 4 only at `cpl`=3, and never in real mode.
- R11: Only one fault is reported, chosen in the priority order UD, NM, MF, SS, GP, PF, AC. With no fault, the code and the vector are both 0.
- R12: `out_valid` equals `req_valid` from the previous cycle. While `out_valid` is 0, the code and the vector are 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| has_mem | input | 1 | Operation uses a memory operand |
| eff_addr | input | AW | Effective address of the memory operand |
| stk_limit_viol | input | 1 | Stack-segment limit exceeded |
| seg_limit_viol | input | 1 | Another segment limit exceeded |
| addr_canonical | input | 1 | Address is in canonical form |
| stack_ref | input | 1 | Address references the stack segment |
| lock_prefix | input | 1 | Lock prefix present |
| cr_emulate | input | 1 | Emulation control bit |
| cr_task_sw | input | 1 | Task-switched control bit |
| cr_os_simd | input | 1 | OS extended-state support bit |
| cr_align_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| simd_feat | input | 1 | Packed-integer extension present |
| x87_pend | input | 1 | x87 exception pending |
| page_fault_in | input | 1 | Translation reported a page fault |
| out_valid | output | 1 | Result valid |
| fault_vec | output | 7 | One-hot fault: bit0 UD, 1 NM, 2 MF, 3 SS, 4 GP, 5 PF, 6 AC |
| fault_code | output | 3 | 0 none, 1 UD, 2 NM, 3 MF, 4 SS, 5 GP, 6 PF, 7 AC |

## Verification
The assertions check on every cycle the output framing. The vector is at most one-hot and agrees with the code. The valid strobe follows the request by one cycle. Outputs are zero when not valid. A lock prefix always yields UD, a 128-bit operation never yields MF, real mode never yields AC, and a raw UD condition always wins over all others. The dependence of each fault on mode, width, privilege and address, including the 0xFFFF boundary, the stack and non-stack split, and conditions being ignored in the wrong mode, is shown only by the bench's directed and random scenarios against its reference model.

// File: rtl/smf_pkg.sv
package smf_pkg;
  localparam int NFAULT = 7;
  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } smf_mode_e;

  // code value = vector bit index + 1
  typedef enum logic [2:0] {
    FC_NONE = 3'd0, FC_UD = 3'd1, FC_NM = 3'd2, FC_MF = 3'd3,
    FC_SS   = 3'd4, FC_GP = 3'd5, FC_PF = 3'd6, FC_AC = 3'd7
  } smf_code_e;

  // low address bits against the natural size of the operand
  function automatic logic is_misaligned(input logic [3:0] low, input logic wide);
    return wide ? (low != 4'd0) : (low[2:0] != 3'd0);
  endfunction

  function automatic logic is_segmented(input logic [2:0] m);
    return (m == MODE_PROT) || (m == MODE_COMPAT);
  endfunction
endpackage

// File: rtl/smf_cond.sv
module smf_cond
  import smf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [2:0]    mode,
  input  logic          wide,
  input  logic          has_mem,
  input  logic [AW-1:0] eff_addr,
  input  logic          stk_limit_viol,
  input  logic          seg_limit_viol,
  input  logic          addr_canonical,
  input  logic          stack_ref,
  input  logic          lock_prefix,
  input  logic          cr_emulate,
  input  logic          cr_task_sw,
  input  logic          cr_os_simd,
  input  logic          cr_align_en,
  input  logic [1:0]    cpl,
  input  logic          simd_feat,
  input  logic          x87_pend,
  input  logic          page_fault_in,
  output logic [NFAULT-1:0] raw
);
  localparam logic [AW:0] REAL_TOP = (AW+1)'(17'h0FFFF);

  logic [AW:0] last_byte;
  logic real_like, long_mode, seg_mode;
  logic ud_any, ud_wide, overrun, noncanon, misal_wide, unal8, ac_priv;

  assign real_like  = (mode == MODE_REAL) || (mode == MODE_V86);
  assign long_mode  = (mode == MODE_LONG);
  assign seg_mode   = is_segmented(mode);
  assign last_byte  = {1'b0, eff_addr} + (wide ? (AW+1)'(15) : (AW+1)'(7));

  assign ud_any     = lock_prefix | cr_emulate;
  assign ud_wide    = wide & (~cr_os_simd | ~simd_feat);
  assign overrun    = has_mem & real_like & (last_byte > REAL_TOP);
  assign noncanon   = has_mem & long_mode & ~addr_canonical;
  assign misal_wide = has_mem & wide & is_misaligned(eff_addr[3:0], 1'b1);
  assign unal8      = is_misaligned(eff_addr[3:0], 1'b0);
  assign ac_priv    = (mode == MODE_V86) || ((seg_mode || long_mode) && cpl == 2'd3);

  always_comb begin
    raw = '0;
    raw[FC_UD-1] = ud_any | ud_wide;
    raw[FC_NM-1] = cr_task_sw;
    raw[FC_MF-1] = ~wide & x87_pend;
    raw[FC_SS-1] = (noncanon & stack_ref) | (has_mem & seg_mode & stk_limit_viol);
    raw[FC_GP-1] = misal_wide | overrun | (noncanon & ~stack_ref)
                 | (has_mem & seg_mode & seg_limit_viol);
    raw[FC_PF-1] = has_mem & (mode != MODE_REAL) & page_fault_in;
    raw[FC_AC-1] = has_mem & ~wide & cr_align_en & unal8 & ac_priv;
  end
endmodule

// File: rtl/smf_prio.sv
module smf_prio #(
  parameter int N  = 7,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  raw,
  output logic [N-1:0]  sel,
  output logic [CW-1:0] code
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign sel[i] = raw[i];
    end else begin : g_rest
      assign sel[i] = raw[i] & ~(|raw[i-1:0]);
    end
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) code = CW'(i + 1);
    end
  end
endmodule

// File: rtl/simd_fault_chk.sv
module simd_fault_chk
  import smf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    mode,
  input  logic          wide,
  input  logic          has_mem,
  input  logic [AW-1:0] eff_addr,
  input  logic          stk_limit_viol,
  input  logic          seg_limit_viol,
  input  logic          addr_canonical,
  input  logic          stack_ref,
  input  logic          lock_prefix,
  input  logic          cr_emulate,
  input  logic          cr_task_sw,
  input  logic          cr_os_simd,
  input  logic          cr_align_en,
  input  logic [1:0]    cpl,
  input  logic          simd_feat,
  input  logic          x87_pend,
  input  logic          page_fault_in,
  output logic          out_valid,
  output logic [6:0]    fault_vec,
  output logic [2:0]    fault_code
);
  logic [NFAULT-1:0] raw_vec;
  logic [NFAULT-1:0] win_vec;
  logic [CODE_W-1:0] win_code;

  smf_cond #(.AW(AW)) u_cond (
    .mode(mode), .wide(wide), .has_mem(has_mem), .eff_addr(eff_addr),
    .stk_limit_viol(stk_limit_viol), .seg_limit_viol(seg_limit_viol),
    .addr_canonical(addr_canonical), .stack_ref(stack_ref),
    .lock_prefix(lock_prefix), .cr_emulate(cr_emulate), .cr_task_sw(cr_task_sw),
    .cr_os_simd(cr_os_simd), .cr_align_en(cr_align_en), .cpl(cpl),
    .simd_feat(simd_feat), .x87_pend(x87_pend), .page_fault_in(page_fault_in),
    .raw(raw_vec)
  );

  smf_prio #(.N(NFAULT), .CW(CODE_W)) u_prio (
    .raw(raw_vec), .sel(win_vec), .code(win_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      fault_vec  <= '0;
      fault_code <= '0;
    end else begin
      out_valid  <= req_valid;
      fault_vec  <= req_valid ? win_vec  : '0;
      fault_code <= req_valid ? win_code : '0;
    end
  end
endmodule

// File: rtl/simd_fault_chk_sva.sv
module simd_fault_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] mode,
  input logic       wide,
  input logic       lock_prefix,
  input logic [6:0] raw_vec,
  input logic       out_valid,
  input logic [6:0] fault_vec,
  input logic [2:0] fault_code
);
  // R12
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R12
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (fault_vec == 7'd0 && fault_code == 3'd0));
  // R11
  vec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_vec));
  // R11
  code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 3'd0) == (fault_vec == 7'd0));
  // R11
  code_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 3'd0) |-> (fault_vec == (7'd1 << (fault_code - 3'd1))));
  // R1
  lock_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lock_prefix) |=> fault_code == 3'd1);
  // R11
  ud_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && raw_vec[0]) |=> fault_vec == 7'd1);
  // R4
  no_mf_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wide) |=> fault_code != 3'd3);
  // R10
  no_ac_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd0) |=> fault_code != 3'd7);
endmodule

bind simd_fault_chk simd_fault_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .wide(wide),
  .lock_prefix(lock_prefix), .raw_vec(raw_vec), .out_valid(out_valid),
  .fault_vec(fault_vec), .fault_code(fault_code)
);

// File: tb/simd_fault_chk_bench.sv
module simd_fault_chk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, wide = 0, has_mem = 0;
  logic [2:0] mode = 3'd2;
  logic [AW-1:0] eff_addr = '0;
  logic stk_limit_viol = 0, seg_limit_viol = 0, addr_canonical = 1, stack_ref = 0;
  logic lock_prefix = 0, cr_emulate = 0, cr_task_sw = 0, cr_os_simd = 1, cr_align_en = 0;
  logic [1:0] cpl = 2'd0;
  logic simd_feat = 1, x87_pend = 0, page_fault_in = 0;
  logic out_valid;
  logic [6:0] fault_vec;
  logic [2:0] fault_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_fault_chk #(.AW(AW)) u_simd_fault_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .wide(wide),
    .has_mem(has_mem), .eff_addr(eff_addr), .stk_limit_viol(stk_limit_viol),
    .seg_limit_viol(seg_limit_viol), .addr_canonical(addr_canonical),
    .stack_ref(stack_ref), .lock_prefix(lock_prefix), .cr_emulate(cr_emulate),
    .cr_task_sw(cr_task_sw), .cr_os_simd(cr_os_simd), .cr_align_en(cr_align_en),
    .cpl(cpl), .simd_feat(simd_feat), .x87_pend(x87_pend),
    .page_fault_in(page_fault_in), .out_valid(out_valid),
    .fault_vec(fault_vec), .fault_code(fault_code)
  );

  // reference: walk the priority list, first hit wins
  function automatic logic [2:0] ref_code();
    longint unsigned last;
    bit gp, ss, protm, realm;
    realm = (mode == 3'd0) || (mode == 3'd1);
    protm = (mode == 3'd2) || (mode == 3'd3);
    last  = longint'(eff_addr) + (wide ? 15 : 7);
    if (lock_prefix || cr_emulate) return 3'd1;
    if (wide && (!cr_os_simd || !simd_feat)) return 3'd1;
    if (cr_task_sw) return 3'd2;
    if (!wide && x87_pend) return 3'd3;
    ss = 0; gp = 0;
    if (has_mem) begin
      if (mode == 3'd4 && !addr_canonical) begin
        if (stack_ref) ss = 1; else gp = 1;
      end
      if (protm && stk_limit_viol) ss = 1;
      if (protm && seg_limit_viol) gp = 1;
      if (wide && (eff_addr % 16) != 0) gp = 1;
      if (realm && last > 64'hFFFF) gp = 1;
    end
    if (ss) return 3'd4;
    if (gp) return 3'd5;
    if (has_mem && mode != 3'd0 && page_fault_in) return 3'd6;
    if (has_mem && !wide && cr_align_en && (eff_addr % 8) != 0 &&
        (mode == 3'd1 || (mode >= 3'd2 && mode <= 3'd4 && cpl == 2'd3))) return 3'd7;
    return 3'd0;
  endfunction

  task automatic expect_out(input string tag, input logic v, input logic [2:0] c);
    logic [6:0] ev;
    ev = (c == 3'd0) ? 7'd0 : (7'd1 << (c - 3'd1));
    checks++;
    if (out_valid !== v || fault_code !== c || fault_vec !== ev) begin
      errors++;
      $display("FAIL %s: valid=%b code=%0d vec=%b expected valid=%b code=%0d vec=%b",
               tag, out_valid, fault_code, fault_vec, v, c, ev);
    end
  endtask

  task automatic clean();
    wide = 0; has_mem = 0; mode = 3'd2; eff_addr = 32'h1000;
    stk_limit_viol = 0; seg_limit_viol = 0; addr_canonical = 1; stack_ref = 0;
    lock_prefix = 0; cr_emulate = 0; cr_task_sw = 0; cr_os_simd = 1;
    cr_align_en = 0; cpl = 0; simd_feat = 1; x87_pend = 0; page_fault_in = 0;
  endtask

  // inputs are set at a falling edge; result checked at the next falling edge
  task automatic run(input string tag, input logic [2:0] want);
    logic [2:0] model;
    model = ref_code();
    req_valid = 1;
    @(negedge clk);
    expect_out(tag, 1'b1, want);
    if (model !== want) begin
      checks++; errors++;
      $display("FAIL %s: reference model=%0d expected=%0d", tag, model, want);
    end
    @(negedge clk);
    clean();
  endtask

  function automatic bit rb(input int n);
    return ($urandom % n) == 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clean();
    @(negedge clk);
    @(negedge clk);
    expect_out("R12 reset", 1'b0, 3'd0);
    rst_n = 1;
    @(negedge clk);

    run("R11 clean", 3'd0);
    lock_prefix = 1; run("R1 lock", 3'd1);
    cr_emulate = 1; wide = 1; run("R1 emulate wide", 3'd1);
    wide = 1; cr_os_simd = 0; run("R2 os bit wide", 3'd1);
    wide = 0; cr_os_simd = 0; simd_feat = 0; run("R2 ignored 64-bit", 3'd0);
    wide = 1; simd_feat = 0; run("R2 feature wide", 3'd1);
    cr_task_sw = 1; run("R3 task switch", 3'd2);
    cr_task_sw = 1; lock_prefix = 1; run("R11 UD over NM", 3'd1);
    x87_pend = 1; run("R4 pending 64-bit", 3'd3);
    x87_pend = 1; wide = 1; run("R4 ignored wide", 3'd0);
    wide = 1; has_mem = 1; eff_addr = 32'h1008; run("R5 misaligned prot", 3'd5);
    wide = 1; has_mem = 1; mode = 3'd0; eff_addr = 32'h1004; run("R5 misaligned real", 3'd5);
    wide = 1; has_mem = 0; eff_addr = 32'h1008; run("R5 no memory", 3'd0);
    mode = 3'd0; has_mem = 1; eff_addr = 32'hFFFC; run("R6 real overrun", 3'd5);
    mode = 3'd0; has_mem = 1; eff_addr = 32'hFFF8; run("R6 real last fits", 3'd0);
    mode = 3'd1; has_mem = 1; wide = 1; eff_addr = 32'hFFF0; run("R6 v86 wide fits", 3'd0);
    mode = 3'd1; has_mem = 1; eff_addr = 32'hFFF9; run("R6 v86 overrun", 3'd5);
    mode = 3'd2; has_mem = 1; eff_addr = 32'hFFFC; run("R6 prot no wrap", 3'd0);
    mode = 3'd4; has_mem = 1; addr_canonical = 0; stack_ref = 1; run("R7 stack", 3'd4);
    mode = 3'd4; has_mem = 1; addr_canonical = 0; run("R7 data", 3'd5);
    mode = 3'd2; has_mem = 1; addr_canonical = 0; run("R7 ignored prot", 3'd0);
    has_mem = 1; stk_limit_viol = 1; run("R8 stack limit", 3'd4);
    mode = 3'd3; has_mem = 1; seg_limit_viol = 1; run("R8 seg limit compat", 3'd5);
    mode = 3'd4; has_mem = 1; seg_limit_viol = 1; stk_limit_viol = 1; run("R8 ignored long", 3'd0);
    has_mem = 1; page_fault_in = 1; run("R9 page fault", 3'd6);
    mode = 3'd0; has_mem = 1; page_fault_in = 1; run("R9 real ignored", 3'd0);
    page_fault_in = 1; run("R9 no memory", 3'd0);
    has_mem = 1; cr_align_en = 1; cpl = 3; eff_addr = 32'h1003; run("R10 cpl3", 3'd7);
    has_mem = 1; cr_align_en = 1; cpl = 0; eff_addr = 32'h1003; run("R10 cpl0", 3'd0);
    mode = 3'd1; has_mem = 1; cr_align_en = 1; eff_addr = 32'h1003; run("R10 v86", 3'd7);
    mode = 3'd0; has_mem = 1; cr_align_en = 1; cpl = 3; eff_addr = 32'h1003; run("R10 real", 3'd0);
    mode = 3'd4; has_mem = 1; cr_align_en = 1; cpl = 3; eff_addr = 32'h1008; run("R10 aligned", 3'd0);
    has_mem = 1; x87_pend = 1; page_fault_in = 1; run("R11 MF over PF", 3'd3);
    has_mem = 1; seg_limit_viol = 1; page_fault_in = 1; run("R11 GP over PF", 3'd5);
    has_mem = 1; seg_limit_viol = 1; stk_limit_viol = 1; run("R11 SS over GP", 3'd4);
    has_mem = 1; page_fault_in = 1; cr_align_en = 1; cpl = 3; eff_addr = 32'h1001;
    run("R11 PF over AC", 3'd6);

    req_valid = 0;
    @(negedge clk);
    expect_out("R12 idle", 1'b0, 3'd0);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] want;
      mode = 3'($urandom % 5);
      wide = rb(2); has_mem = !rb(4);
      eff_addr = $urandom;
      if (rb(2)) eff_addr[3:0] = 4'd0;
      if (rb(3)) eff_addr = 32'hFFE8 + ($urandom % 24);
      stk_limit_viol = rb(10); seg_limit_viol = rb(10);
      addr_canonical = !rb(8); stack_ref = rb(2);
      lock_prefix = rb(20); cr_emulate = rb(20); cr_task_sw = rb(12);
      cr_os_simd = !rb(12); simd_feat = !rb(12); cr_align_en = rb(2);
      cpl = 2'($urandom % 4); x87_pend = rb(10); page_fault_in = rb(8);
      want = ref_code();
      req_valid = 1;
      @(negedge clk);
      expect_out("R11 random", 1'b1, want);
    end
    req_valid = 0;
    @(negedge clk);
    expect_out("R12 final idle", 1'b0, 3'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule